// File: doc/BRIEF.md
# ALU Status Flag Generator

This block holds the nine-bit condition and control flag state of a 16-bit processor core. Each cycle it takes one operation code together with the operands, the result and the raw adder carry outputs of the neighbouring arithmetic datapath, plus a byte/word width select. From these it updates the carry, parity, half-carry, zero, sign and overflow flags. It also executes the single-flag control operations for the carry, direction and interrupt-enable bits.

The state is always presented as a packed 16-bit flag word. This word is what a stack save stores. A full-word load restores it, for example on a return from an interrupt. All updates are registered: the effect of an operation applied in one cycle is visible on `flags_o` from the following cycle onward. The arithmetic result itself is produced outside this block.

Flag word layout: carry bit 0, parity bit 2, half-carry bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt-enable bit 9, direction bit 10, overflow bit 11. Operation codes on `op_i` are: 0 hold, 1 add, 2 subtract, 3 logic, 4 set carry, 5 clear carry, 6 complement carry, 7 set direction, 8 clear direction, 9 set interrupt-enable, 10 clear interrupt-enable, 11 load word. Codes 12 to 15 behave as hold.

Top module: `alu_flag_unit`

## Requirements
- R1: After the asynchronous reset all nine flags are 0, so `flags_o` reads 16'hF000.
- R2: The undefined bits of `flags_o` always read as fixed values: 1 in bits 15..12, and 0 in bits 5, 3 and 1.
- R3: After an add (1), subtract (2) or logic (3) operation, zero (bit 6) is set exactly when `res_i` is zero at the selected width. Sign (bit 7) equals the top bit of `res_i` at that width: bit 7 when `word_i`=0, bit 15 when `word_i`=1.
- R4: After op 1, 2 or 3, parity (bit 2) is 1 when `res_i[7:0]` holds an even number of ones, and 0 otherwise. This holds for both widths.
- R5: After op 1 or 2, half-carry (bit 4) is the carry (add) or borrow (subtract) from bit 3 into bit 4 of `opa_i` op `opb_i`.
- R6: After op 1 or 2, carry (bit 0) is the unsigned carry out (add) or borrow (subtract) at the selected width. `cy_i[0]` is the raw adder carry out of bit 7 and `cy_i[1]` is the raw adder carry out of bit 15. For a subtract the adder computes `opa_i + ~opb_i + 1`, so the borrow is the inverted raw carry.
- R7: After op 1 or 2, overflow (bit 11) is 1 exactly when the signed sum or difference falls outside the range of the selected width.
- R8: After a logic operation (3), carry and overflow are 0 and half-carry keeps its previous value.
- R9: Set carry (4), clear carry (5) and complement carry (6) change only bit 0 of the flag word.
- R10: Set/clear direction (7/8) change only bit 10, and set/clear interrupt-enable (9/10) change only bit 9.
- R11: A load (11) copies the nine defined positions of `flags_i` into the flags. Values written to the undefined positions of `flags_i` are ignored. Load is the only operation that changes trap (bit 8).
- R12: Hold (0) leaves the flag word unchanged, and ops 1, 2 and 3 leave trap, interrupt-enable and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code for this cycle |
| word_i | input | 1 | Width select: 1 word, 0 byte |
| opa_i | input | 16 | First operand of the datapath |
| opb_i | input | 16 | Second operand (subtrahend for subtract) |
| res_i | input | 16 | Datapath result |
| cy_i | input | 2 | Raw adder carry out of bit 7 [0] and bit 15 [1] |
| flags_i | input | 16 | Flag word to load |
| flags_o | output | 16 | Packed flag word |

## Verification
The bench targets byte operations whose low byte is zero while the upper byte is not. A design that tests zero or sign over 16 bits would miss ZF there or copy the wrong bit into SF. Word results whose low byte has even parity while the whole word does not separate an 8-bit parity tree from a 16-bit one. Byte operations are driven with the word-level carry deliberately set to the opposite value, so a wrong carry select shows up as a flipped CF. Signed-boundary adds and subtracts, such as 0x7F+1 and 0x8000-1, catch an overflow formula swapped between add and subtract. Control operations are checked on a flag word preloaded with all ones, so any neighbouring bit they disturb becomes visible.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int FLAG_W = 16;

  localparam int B_CF = 0;
  localparam int B_PF = 2;
  localparam int B_AF = 4;
  localparam int B_ZF = 6;
  localparam int B_SF = 7;
  localparam int B_TF = 8;
  localparam int B_IF = 9;
  localparam int B_DF = 10;
  localparam int B_OF = 11;

  localparam logic [FLAG_W-1:0] HOLE_ONES = 16'hF000;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_LOGIC = 4'd3,
    OP_STC   = 4'd4,
    OP_CLC   = 4'd5,
    OP_CMC   = 4'd6,
    OP_STD   = 4'd7,
    OP_CLD   = 4'd8,
    OP_STI   = 4'd9,
    OP_CLI   = 4'd10,
    OP_LOAD  = 4'd11
  } flag_op_e;

  typedef struct packed {
    logic f_of;
    logic f_df;
    logic f_if;
    logic f_tf;
    logic f_sf;
    logic f_zf;
    logic f_af;
    logic f_pf;
    logic f_cf;
  } flag_state_t;

  typedef struct packed {
    logic c_of;
    logic c_sf;
    logic c_zf;
    logic c_af;
    logic c_pf;
    logic c_cf;
  } cond_t;
endpackage

// File: rtl/flagu_cond.sv
module flagu_cond
  import flagu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          word_i,
  input  logic          sub_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] res_i,
  input  logic [1:0]    cy_i,
  output cond_t         cond_o
);
  localparam int BW = DW / 2;
  localparam int NW = BW / 2;

  logic sa, sb, sr, raw_cy, zero_w, zero_b;

  // width select for sign bits and carry
  always_comb begin
    if (word_i) begin
      sa     = opa_i[DW-1];
      sb     = opb_i[DW-1];
      sr     = res_i[DW-1];
      raw_cy = cy_i[1];
    end else begin
      sa     = opa_i[BW-1];
      sb     = opb_i[BW-1];
      sr     = res_i[BW-1];
      raw_cy = cy_i[0];
    end
  end

  assign zero_b = (res_i[BW-1:0] == '0);
  assign zero_w = zero_b && (res_i[DW-1:BW] == '0);

  always_comb begin
    cond_o.c_zf = word_i ? zero_w : zero_b;
    cond_o.c_sf = sr;
    cond_o.c_pf = ~^res_i[BW-1:0];
    // carry or borrow into the nibble boundary
    cond_o.c_af = opa_i[NW] ^ opb_i[NW] ^ res_i[NW];
    cond_o.c_cf = raw_cy ^ sub_i;
    if (sub_i) cond_o.c_of = (sa != sb) && (sr != sa);
    else       cond_o.c_of = (sa == sb) && (sr != sa);
  end

  logic unused_opnd;
  assign unused_opnd = ^{opa_i, opb_i};
endmodule

// File: rtl/flagu_pack.sv
module flagu_pack
  import flagu_pkg::*;
(
  input  flag_state_t       st_i,
  input  logic [FLAG_W-1:0] ld_word_i,
  output logic [FLAG_W-1:0] word_o,
  output flag_state_t       ld_st_o
);
  always_comb begin
    word_o       = HOLE_ONES;
    word_o[B_CF] = st_i.f_cf;
    word_o[B_PF] = st_i.f_pf;
    word_o[B_AF] = st_i.f_af;
    word_o[B_ZF] = st_i.f_zf;
    word_o[B_SF] = st_i.f_sf;
    word_o[B_TF] = st_i.f_tf;
    word_o[B_IF] = st_i.f_if;
    word_o[B_DF] = st_i.f_df;
    word_o[B_OF] = st_i.f_of;
  end

  always_comb begin
    ld_st_o.f_cf = ld_word_i[B_CF];
    ld_st_o.f_pf = ld_word_i[B_PF];
    ld_st_o.f_af = ld_word_i[B_AF];
    ld_st_o.f_zf = ld_word_i[B_ZF];
    ld_st_o.f_sf = ld_word_i[B_SF];
    ld_st_o.f_tf = ld_word_i[B_TF];
    ld_st_o.f_if = ld_word_i[B_IF];
    ld_st_o.f_df = ld_word_i[B_DF];
    ld_st_o.f_of = ld_word_i[B_OF];
  end

  logic unused_holes;
  assign unused_holes = ^{ld_word_i[15:12], ld_word_i[5], ld_word_i[3], ld_word_i[1]};
endmodule

// File: rtl/flagu_next.sv
module flagu_next
  import flagu_pkg::*;
(
  input  flag_op_e    op_i,
  input  flag_state_t cur_i,
  input  cond_t       cond_i,
  input  flag_state_t ld_i,
  output flag_state_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    case (op_i)
      OP_ADD, OP_SUB: begin
        nxt_o.f_cf = cond_i.c_cf;
        nxt_o.f_pf = cond_i.c_pf;
        nxt_o.f_af = cond_i.c_af;
        nxt_o.f_zf = cond_i.c_zf;
        nxt_o.f_sf = cond_i.c_sf;
        nxt_o.f_of = cond_i.c_of;
      end
      OP_LOGIC: begin
        nxt_o.f_cf = 1'b0;
        nxt_o.f_of = 1'b0;
        nxt_o.f_pf = cond_i.c_pf;
        nxt_o.f_zf = cond_i.c_zf;
        nxt_o.f_sf = cond_i.c_sf;
      end
      OP_STC:  nxt_o.f_cf = 1'b1;
      OP_CLC:  nxt_o.f_cf = 1'b0;
      OP_CMC:  nxt_o.f_cf = ~cur_i.f_cf;
      OP_STD:  nxt_o.f_df = 1'b1;
      OP_CLD:  nxt_o.f_df = 1'b0;
      OP_STI:  nxt_o.f_if = 1'b1;
      OP_CLI:  nxt_o.f_if = 1'b0;
      OP_LOAD: nxt_o = ld_i;
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flagu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic              word_i,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  input  logic [DW-1:0]     res_i,
  input  logic [1:0]        cy_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  flag_op_e    op;
  flag_state_t st_q, st_d, ld_st;
  cond_t       cond;

  assign op = flag_op_e'(op_i);

  flagu_cond #(.DW(DW)) u_cond (
    .word_i (word_i),
    .sub_i  (op == OP_SUB),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .res_i  (res_i),
    .cy_i   (cy_i),
    .cond_o (cond)
  );

  flagu_pack u_pack (
    .st_i      (st_q),
    .ld_word_i (flags_i),
    .word_o    (flags_o),
    .ld_st_o   (ld_st)
  );

  flagu_next u_next (
    .op_i   (op),
    .cur_i  (st_q),
    .cond_i (cond),
    .ld_i   (ld_st),
    .nxt_o  (st_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import flagu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic [FLAG_W-1:0] flags_o
);
  localparam logic [FLAG_W-1:0] DEF_MASK = 16'h0FD5;

  assert_holes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[15:12] == 4'hF) && !flags_o[5] && !flags_o[3] && !flags_o[1]);

  assert_stc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STC) |=> flags_o[B_CF] && (flags_o[15:1] == $past(flags_o[15:1])));

  assert_cmc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMC) |=> (flags_o[B_CF] != $past(flags_o[B_CF]))
                         && (flags_o[15:1] == $past(flags_o[15:1])));

  assert_std_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STD) |=> flags_o[B_DF] && (flags_o[9:0] == $past(flags_o[9:0]))
                         && (flags_o[15:11] == $past(flags_o[15:11])));

  assert_cli_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLI) |=> !flags_o[B_IF] && (flags_o[8:0] == $past(flags_o[8:0]))
                         && (flags_o[15:10] == $past(flags_o[15:10])));

  assert_logic_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOGIC) |=> !flags_o[B_CF] && !flags_o[B_OF] && $stable(flags_o[B_AF]));

  assert_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> ((flags_o & DEF_MASK) == ($past(flags_i) & DEF_MASK)));

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NOP) |=> $stable(flags_o));

  assert_ctl_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_LOGIC) |=> $stable(flags_o[10:8]));
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .flags_i (flags_i),
  .flags_o (flags_o)
);

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        word = 1'b0;
  logic [15:0] opa = '0, opb = '0, res = '0, fl_in = '0;
  logic [1:0]  cy = '0;
  logic [15:0] fl_out;
  logic [15:0] exp_w = 16'hF000;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  alu_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .word_i(word),
    .opa_i(opa), .opb_i(opb), .res_i(res), .cy_i(cy),
    .flags_i(fl_in), .flags_o(fl_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  // drive at a negedge, result visible at the next negedge
  task automatic apply(input logic [3:0] o);
    op = o;
    @(negedge clk);
    op = 4'd0;
  endtask

  task automatic t_arith(input string req, input bit sub, input bit wd,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] junk);
    int w = wd ? 16 : 8;
    longint m = (longint'(1) << w) - 1;
    longint ua = a & m, ub = b & m, ur;
    longint sa, sb, sres;
    bit c, raw, af, of;
    logic [15:0] r;
    ur = sub ? (ua - ub) & m : (ua + ub) & m;
    if (sub) begin c = ua < ub; raw = !c; af = (ua & 15) < (ub & 15); end
    else begin raw = ((ua + ub) >> w) & 1; c = raw; af = ((ua & 15) + (ub & 15)) > 15; end
    sa = (ua >> (w-1)) ? ua - (longint'(1) << w) : ua;
    sb = (ub >> (w-1)) ? ub - (longint'(1) << w) : ub;
    sres = sub ? sa - sb : sa + sb;
    of = (sres > (longint'(1) << (w-1)) - 1) || (sres < -(longint'(1) << (w-1)));
    r = wd ? 16'(ur) : {junk, 8'(ur)};
    word = wd; res = r;
    opa = wd ? a : {junk ^ 8'h5A, a[7:0]};
    opb = wd ? b : {junk ^ 8'hC3, b[7:0]};
    cy = wd ? {raw, !raw} : {!raw, raw};
    exp_w[0] = c;
    exp_w[2] = ~^r[7:0];
    exp_w[4] = af;
    exp_w[6] = wd ? (r == 16'h0) : (r[7:0] == 8'h0);
    exp_w[7] = wd ? r[15] : r[7];
    exp_w[11] = of;
    apply(sub ? 4'd2 : 4'd1);
    chk(req, fl_out, exp_w);
  endtask

  task automatic t_logic(input string req, input bit wd, input logic [15:0] r);
    word = wd; res = r; opa = 16'hA5A5; opb = 16'h0FF0; cy = 2'b11;
    exp_w[0] = 1'b0;
    exp_w[11] = 1'b0;
    exp_w[2] = ~^r[7:0];
    exp_w[6] = wd ? (r == 16'h0) : (r[7:0] == 8'h0);
    exp_w[7] = wd ? r[15] : r[7];
    apply(4'd3);
    chk(req, fl_out, exp_w);
  endtask

  task automatic t_load(input string req, input logic [15:0] v);
    fl_in = v;
    exp_w = (v & 16'h0FD5) | 16'hF000;
    apply(4'd11);
    fl_in = ~v;
    chk(req, fl_out, exp_w);
  endtask

  task automatic t_ctl(input string req, input logic [3:0] o, input int pos, input int kind);
    if (kind == 0) exp_w[pos] = 1'b1;
    else if (kind == 1) exp_w[pos] = 1'b0;
    else exp_w[pos] = ~exp_w[pos];
    apply(o);
    chk(req, fl_out, exp_w);
  endtask

  task automatic t_reset();
    chk("R1 reset value", fl_out, 16'hF000);
  endtask

  task automatic t_hold();
    op = 4'd0;
    repeat (3) @(negedge clk);
    chk("R12 hold", fl_out, exp_w);
    apply(4'd14);
    chk("R12 unused code holds", fl_out, exp_w);
  endtask

  task automatic t_carry_ctl();
    t_load("R11 load ones", 16'hFFFF);
    chk("R2 holes after ones load", fl_out, 16'hFFD5);
    t_ctl("R9 clear carry", 4'd5, 0, 1);
    t_ctl("R9 complement carry", 4'd6, 0, 2);
    t_ctl("R9 complement carry again", 4'd6, 0, 2);
    t_ctl("R9 set carry", 4'd4, 0, 0);
  endtask

  task automatic t_dir_int();
    t_ctl("R10 clear direction", 4'd8, 10, 1);
    t_ctl("R10 clear interrupt", 4'd10, 9, 1);
    t_load("R11 load zeros", 16'h0000);
    t_ctl("R10 set direction", 4'd7, 10, 0);
    t_ctl("R10 set interrupt", 4'd9, 9, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    // byte add: signed overflow, half carry
    t_arith("R3 R4 R5 R6 R7 byte 7F+01", 1'b0, 1'b0, 16'h007F, 16'h0001, 8'h00);
    // byte add wrapping to zero with upper junk
    t_arith("R3 R6 byte zero with upper junk", 1'b0, 1'b0, 16'h00FF, 16'h0001, 8'h9C);
    t_arith("R3 R6 R7 word 8000+8000", 1'b0, 1'b1, 16'h8000, 16'h8000, 8'h00);
    t_arith("R4 R5 word 1234+0F0F", 1'b0, 1'b1, 16'h1234, 16'h0F0F, 8'h00);
    t_arith("R4 word 00FF+0001 low-byte parity", 1'b0, 1'b1, 16'h00FF, 16'h0001, 8'h00);
    t_arith("R5 R6 byte 00-01 borrow", 1'b1, 1'b0, 16'h0000, 16'h0001, 8'h3E);
    t_arith("R7 word 8000-0001", 1'b1, 1'b1, 16'h8000, 16'h0001, 8'h00);
    t_arith("R3 R6 word 5555-5555", 1'b1, 1'b1, 16'h5555, 16'h5555, 8'h00);
    t_arith("R7 byte 80-01", 1'b1, 1'b0, 16'h0080, 16'h0001, 8'h01);
    t_carry_ctl();
    t_arith("R12 add keeps control flags", 1'b0, 1'b1, 16'h0FFF, 16'h0001, 8'h00);
    t_logic("R8 logic word 8001", 1'b1, 16'h8001);
    t_logic("R8 logic byte zero upper junk", 1'b0, 16'h7700);
    t_dir_int();
    t_load("R11 holes ignored", 16'hF02A);
    t_load("R11 trap via load", 16'h0100);
    t_arith("R12 sub keeps trap", 1'b1, 1'b1, 16'h0003, 16'h0007, 8'h00);
    t_logic("R12 logic keeps trap", 1'b1, 16'h0000);
    chk("R2 holes final", fl_out & 16'hF02A, 16'hF000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule